// File: doc/BRIEF.md
# Serial Bit-Change Detector

This block watches a single serial data bit, sampled once per clock, and raises its `detect` output whenever the newest bit differs from the one before it. In other words, it flags the pairs "01" and "10" in the stream. Constant runs keep it low. An alternating stream keeps it high on every bit after the first.

One parameter picks the implementation when the design is built. The port list is the same either way.

- **State-driven form.** It has five states and the output is a pure decode of the state register. A change is reported in the clock cycle after the edge that captured the second bit of the pair.
- **Arc-driven form.** It has three states, and the output combines the stored last bit with the bit currently on the input. The same change is therefore reported one cycle earlier, while that second bit is still being presented.

Reset is synchronous and active-high. It clears the stored history, so the first bit after reset never counts as a change.

Top module: `bit_change_det`

## Requirements
- R1: While `rst` is high at a clock edge, the detector's history is cleared. In the arc-driven form (`USE_MEALY=1`), `detect` is 0 in every cycle in which `rst` is high. In the state-driven form (`USE_MEALY=0`), `detect` is 0 in the cycle after any edge at which `rst` was high.
- R2: The first bit captured after reset is never reported as a change, in either form.
- R3: In the state-driven form, `detect` is 1 in the cycle following the edge that captured bit k exactly when bit k differs from bit k-1, where both bits were captured after the last reset. Otherwise it is 0.
- R4: In the arc-driven form, `detect` is 1 during a cycle exactly when `rst` is low, at least one bit has been captured since reset, and the bit now on `bitIn` differs from the last captured bit. The output follows `bitIn` in the same cycle.
- R5: A run of equal bits keeps `detect` at 0, in either form.
- R6: An alternating stream 0,1,0,1,... keeps `detect` at 1 for every bit after the first, in either form.
- R7: For any stream, the state-driven form's `detect` in cycle t equals the arc-driven form's `detect` in cycle t-1.
- R8: A reset in the middle of a stream discards the stored bit. The first bit after it is not compared with the bit that came before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bitIn | input | 1 | Serial data bit, one per clock |
| detect | output | 1 | High when the newest bit differs from the previous one |

## Verification
The bench feeds one stream into both forms at once and checks the following:

- **Reset and first bit.** It checks the cycles around reset release and the first bit after it. A design that kept stale history or started from the wrong state would flag a change there.
- **Long runs and alternation.** Long constant runs and long alternating runs catch swapped transition targets, such as one of the two "changed" states looping back onto itself, which drops or invents pulses.
- **Random stream and relative timing.** A random stream with resets in the middle of it is compared cycle by cycle against a behavioural model. The two forms are also compared against each other. An arc-driven output that was accidentally registered, or a state-driven output that leaked the live input, would break the one-cycle offset between them.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [2:0] {
    MO_IDLE   = 3'd0,
    MO_ZERO   = 3'd1,
    MO_ONE    = 3'd2,
    MO_ROSE   = 3'd3,
    MO_FELL   = 3'd4
  } mooreState_t;

  typedef enum logic [1:0] {
    ML_IDLE = 2'd0,
    ML_ZERO = 2'd1,
    ML_ONE  = 2'd2
  } mealyState_t;

  typedef struct packed {
    logic histValid;
    logic histBit;
    logic markNow;
  } bcdStrobe_t;

endpackage

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
#(
  parameter bit USE_MEALY = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitIn,
  output bcdStrobe_t strb
);

  generate
    if (USE_MEALY) begin : g_mealy
      mealyState_t curS, nxtS;

      always_comb begin
        nxtS = bitIn ? ML_ONE : ML_ZERO;
      end

      always_ff @(posedge clk) begin
        if (rst) curS <= ML_IDLE;
        else     curS <= nxtS;
      end

      always_comb begin
        strb.histValid = (curS != ML_IDLE);
        strb.histBit   = (curS == ML_ONE);
        strb.markNow   = 1'b0;
      end
    end else begin : g_moore
      mooreState_t curS, nxtS;

      always_comb begin
        nxtS = curS;
        unique case (curS)
          MO_IDLE: nxtS = bitIn ? MO_ONE  : MO_ZERO;
          MO_ZERO: nxtS = bitIn ? MO_ROSE : MO_ZERO;
          MO_ONE:  nxtS = bitIn ? MO_ONE  : MO_FELL;
          MO_ROSE: nxtS = bitIn ? MO_ONE  : MO_FELL;
          MO_FELL: nxtS = bitIn ? MO_ROSE : MO_ZERO;
          default: nxtS = MO_IDLE;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) curS <= MO_IDLE;
        else     curS <= nxtS;
      end

      always_comb begin
        strb.histValid = (curS != MO_IDLE);
        strb.histBit   = (curS == MO_ONE) || (curS == MO_ROSE);
        strb.markNow   = (curS == MO_ROSE) || (curS == MO_FELL);
      end
    end
  endgenerate

endmodule

// File: rtl/bcd_dpath.sv
module bcd_dpath
  import bcd_pkg::*;
#(
  parameter bit USE_MEALY = 1'b0
) (
  input  logic       rst,
  input  logic       bitIn,
  input  bcdStrobe_t strb,
  output logic       detect
);

  generate
    if (USE_MEALY) begin : g_arc
      logic unusedArc;
      assign unusedArc = strb.markNow;
      assign detect = !rst && strb.histValid && (strb.histBit ^ bitIn);
    end else begin : g_state
      logic unusedState;
      assign unusedState = ^{rst, bitIn, strb.histValid, strb.histBit};
      assign detect = strb.markNow;
    end
  endgenerate

endmodule

// File: rtl/bit_change_det.sv
module bit_change_det
  import bcd_pkg::*;
#(
  parameter bit USE_MEALY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bitIn,
  output logic detect
);

  bcdStrobe_t strb;

  bcd_ctrl #(.USE_MEALY(USE_MEALY)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .bitIn (bitIn),
    .strb  (strb)
  );

  bcd_dpath #(.USE_MEALY(USE_MEALY)) u_dpath (
    .rst    (rst),
    .bitIn  (bitIn),
    .strb   (strb),
    .detect (detect)
  );

endmodule

// File: rtl/bit_change_det_chk.sv
module bit_change_det_chk #(
  parameter bit USE_MEALY = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic bitIn,
  input logic detect
);

  logic lastBit, lastValid, olderBit, olderValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastValid  <= 1'b0;
      olderValid <= 1'b0;
      lastBit    <= 1'b0;
      olderBit   <= 1'b0;
    end else begin
      lastValid  <= 1'b1;
      olderValid <= lastValid;
      lastBit    <= bitIn;
      olderBit   <= lastBit;
    end
  end

  generate
    if (USE_MEALY) begin : g_arcChk
      // R1
      arc_rst_low_chk: assert property (@(posedge clk) rst |-> !detect);
      // R2
      arc_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !lastValid |-> !detect);
      // R4
      arc_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        lastValid |-> (detect == (bitIn != lastBit)));
    end else begin : g_stateChk
      // R1
      state_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !lastValid |-> !detect);
      // R2
      state_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (lastValid && !olderValid) |-> !detect);
      // R3
      state_late_chk: assert property (@(posedge clk) disable iff (rst)
        olderValid |-> (detect == (lastBit != olderBit)));
      // R5
      state_run_low_chk: assert property (@(posedge clk) disable iff (rst)
        (olderValid && (lastBit == olderBit)) |-> !detect);
    end
  endgenerate

endmodule

bind bit_change_det bit_change_det_chk #(.USE_MEALY(USE_MEALY)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bitIn  (bitIn),
  .detect (detect)
);

// File: tb/bit_change_det_bench.sv
`timescale 1ns/1ps
module bit_change_det_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0;
  logic detMoore, detMealy;

  always #2.5 clk = ~clk;

  bit_change_det #(.USE_MEALY(1'b0)) u_bit_change_det (
    .clk(clk), .rst(rst), .bitIn(bitIn), .detect(detMoore));

  bit_change_det #(.USE_MEALY(1'b1)) u_bit_change_det_arc (
    .clk(clk), .rst(rst), .bitIn(bitIn), .detect(detMealy));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural reference model
  int lastSeen = -1;       // -1: no bit since reset
  bit expMooreQ = 1'b0;
  bit prevMealyAct = 1'b0;
  bit havePrev = 1'b0;

  task automatic checkOne(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle: set inputs at negedge, check, then model the edge
  task automatic step(input logic r, input logic b, input string tagMo,
                      input string tagMl, input bit cmpForms);
    bit expMealy;
    @(negedge clk);
    rst = r;
    bitIn = b;
    #1;
    expMealy = !r && (lastSeen >= 0) && (int'(b) != lastSeen);
    checkOne(tagMo, detMoore, expMooreQ);
    checkOne(tagMl, detMealy, expMealy);
    if (cmpForms && havePrev) checkOne("R7", detMoore, prevMealyAct);
    prevMealyAct = detMealy;
    havePrev = 1'b1;
    @(posedge clk);
    expMooreQ = expMealy;
    lastSeen = r ? -1 : int'(b);
  endtask

  initial begin
    // R1: held in reset
    for (int i = 0; i < 3; i++) step(1'b1, 1'(i), "R1", "R1", 1'b0);
    // R2: first bit after reset, then its follower
    step(1'b0, 1'b1, "R2", "R2", 1'b0);
    step(1'b0, 1'b1, "R2", "R5", 1'b0);
    // R5: constant runs
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R5", "R5", 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R5", "R5", 1'b0);
    // R6: alternation
    for (int i = 0; i < 12; i++) step(1'b0, 1'(i), "R6", "R6", 1'b0);
    // R8: reset mid-stream, next bit opposite to the one before reset
    step(1'b0, 1'b1, "R8", "R8", 1'b0);
    step(1'b1, 1'b0, "R8", "R1", 1'b0);
    step(1'b0, 1'b0, "R8", "R8", 1'b0);
    step(1'b0, 1'b0, "R8", "R8", 1'b0);
    // R3 / R4 / R7: random stream with occasional resets
    for (int i = 0; i < 400; i++) begin
      logic r;
      r = (($urandom % 37) == 0);
      step(r, 1'($urandom), "R3", "R4", 1'b1);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule